// File: doc/BRIEF.md
# Half-Step and Fractional Clock Enable Divider

This block derives a divided clock-enable pulse stream from a free-running clock. The pulses come through two cascaded stages. A pre-divider divides by whole or half-step ratios: a half step is produced by alternating the spacing between two neighbouring whole numbers. A fractional rate stage follows it. When enabled, this stage passes `m` of every `n` pre-divider ticks, using an accumulator that spreads the pulses as evenly as it can.

The configuration arrives as raw register fields. The pre-divider field holds twice the ratio minus one. The rate stage takes `m` directly. It takes `n` in complemented form twice: once as the complement of `n - m` and once as the complement of `n`. The block keeps a private copy of these fields and adopts a new setting only when an output pulse fires. A change therefore never cuts an output interval short.

Top module: `frac_clk_div`

## Requirements
- R1: While `rst_n` is low, `div_pulse` is 0 and the held configuration clears to divide-by-one with the rate stage bypassed. `div_pulse` is therefore 1 on the first cycle after reset is released.
- R2: A pre-divider field value of 0 or 1 divides by one: with the rate stage bypassed, `div_pulse` is 1 on every cycle.
- R3: An odd pre-divider field value k of 3 or more gives exactly (k+1)/2 cycles between consecutive pulses.
- R4: An even pre-divider field value k of 2 or more gives a ratio of (k+1)/2. Consecutive gaps alternate strictly between k/2 and k/2+1 cycles.
- R5: The largest pre-divider field value, 2^HID_W-1, gives a spacing of 2^(HID_W-1) cycles. The internal down-counter never exceeds half the held field value.
- R6: The rate stage is active when the mode field equals 2, n is nonzero and 0 < m < n. In that case, over any window of n*r2*j cycles, where r2 = max(k,1)+1, exactly 2*m*j pulses appear. The rate field holds m. The field for the difference holds ~(n-m) and the field for the modulus holds ~n, each masked to MND_W bits.
- R7: Each of the following bypasses the rate stage, so every pre-divider tick becomes a pulse: a mode field other than 2, n = 0 (modulus field all ones), m = 0, or m >= n.
- R8: With the rate stage active, every gap between pulses is floor(n/m) or ceil(n/m) pre-divider ticks.
- R9: A new configuration is adopted only on the cycle an output pulse fires. The interval already running ends on its old spacing. When the setting differs, the accumulator clears and the half-step phase restarts, so the first rate-stage gap after the change is exactly ceil(n/m) ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prediv | input | HID_W | Pre-divider field, twice the ratio minus one |
| cfg_mode | input | 2 | Rate stage mode, 2 selects the fractional stage |
| cfg_m | input | MND_W | Rate numerator m |
| cfg_n_inv | input | MND_W | Complement of n - m |
| cfg_d_inv | input | MND_W | Complement of n |
| div_pulse | output | 1 | Registered divided clock-enable pulse |

## Verification
A wrong pre-divider count or phase shows up at the next pulse: a gap is one cycle too long or too short, or two equal gaps appear where they must alternate. An accumulator that keeps a stale residue across a configuration change shows up as a wrong first gap after the change. A residue that drifts shows up as a pulse count that is off over one full pattern window, which is at most n*(k+1) cycles. A configuration adopted too early cuts short the interval that is running, and this is visible within one old period.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
   typedef enum logic [1:0] {
      FCD_MODE_OFF  = 2'd0,
      FCD_MODE_R1   = 2'd1,
      FCD_MODE_DUAL = 2'd2,
      FCD_MODE_R3   = 2'd3
   } fcd_mode_e;
endpackage

// File: rtl/fcd_prestage.sv
// Half-step pre-divider: emits one tick per period, period from field k.
module fcd_prestage #(
   parameter int HID_W     = 5,
   parameter bit HALF_STEP = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [HID_W-1:0] cur_k,
   input  logic [HID_W-1:0] next_k,
   input  logic             load,
   input  logic             restart,
   output logic             tick,
   output logic [HID_W-1:0] cnt_o
);
   logic [HID_W-1:0] cnt_q;
   logic             phase_q;
   logic             nph;
   logic             ph_use;
   logic [HID_W-1:0] use_k;

   // span minus one for field k; ph selects ceiling half of a half step
   function automatic logic [HID_W-1:0] span_m1(input logic [HID_W-1:0] k,
                                                 input logic ph);
      logic [HID_W-1:0] half;
      half = k >> 1;
      if (k <= HID_W'(1))  return '0;
      else if (k[0])       return half;
      else if (ph)         return half;
      else                 return half - HID_W'(1);
   endfunction

   assign tick  = (cnt_q == '0);
   assign cnt_o = cnt_q;
   assign use_k = load ? next_k : cur_k;
   assign nph   = restart ? 1'b0 : ~phase_q;

   generate
      if (HALF_STEP) begin : g_half
         assign ph_use = nph;
      end else begin : g_ceil
         assign ph_use = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         phase_q <= 1'b1;
      end else if (tick) begin
         cnt_q   <= span_m1(use_k, ph_use);
         phase_q <= nph;
      end else begin
         cnt_q   <= cnt_q - HID_W'(1);
      end
   end
endmodule

// File: rtl/fcd_mnd_stage.sv
// Fractional rate stage: passes m of every n ticks via an accumulator.
module fcd_mnd_stage
   import fcd_pkg::*;
#(
   parameter int MND_W  = 8,
   parameter bit ENABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             restart,
   input  logic [1:0]       mode,
   input  logic [MND_W-1:0] m,
   input  logic [MND_W-1:0] n_inv,
   input  logic [MND_W-1:0] d_inv,
   output logic             hit,
   output logic             active,
   output logic [MND_W-1:0] acc_o
);
   generate
      if (ENABLE) begin : g_mnd
         logic [MND_W-1:0] acc_q;
         logic [MND_W-1:0] n_dec;
         logic [MND_W-1:0] nm_dec;
         logic [MND_W:0]   sum;
         logic             reach;

         assign n_dec  = ~d_inv;
         assign nm_dec = ~n_inv;
         assign active = (fcd_mode_e'(mode) == FCD_MODE_DUAL) &&
                         (n_dec != '0) && (m != '0) && (m < n_dec);
         assign sum    = {1'b0, acc_q} + {1'b0, m};
         assign reach  = (sum >= {1'b0, n_dec});
         assign hit    = tick && (!active || reach);
         assign acc_o  = acc_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               acc_q <= '0;
            end else if (tick) begin
               if (restart || !active) acc_q <= '0;
               else if (reach)         acc_q <= acc_q - nm_dec;
               else                    acc_q <= sum[MND_W-1:0];
            end
         end
      end else begin : g_pass
         assign hit    = tick;
         assign active = 1'b0;
         assign acc_o  = '0;
      end
   endgenerate
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div #(
   parameter int HID_W     = 5,
   parameter int MND_W     = 8,
   parameter bit HALF_STEP = 1'b1,
   parameter bit USE_MND   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [HID_W-1:0] cfg_prediv,
   input  logic [1:0]       cfg_mode,
   input  logic [MND_W-1:0] cfg_m,
   input  logic [MND_W-1:0] cfg_n_inv,
   input  logic [MND_W-1:0] cfg_d_inv,
   output logic             div_pulse
);
   localparam int CFG_W = HID_W + 2 + 3 * MND_W;

   generate
      if (HID_W < 2 || HID_W > 16) begin : g_bad_hid
         $error("frac_clk_div: HID_W out of range");
      end
      if (MND_W < 2 || MND_W > 24) begin : g_bad_mnd
         $error("frac_clk_div: MND_W out of range");
      end
   endgenerate

   logic [HID_W-1:0] sh_pre;
   logic [1:0]       sh_mode;
   logic [MND_W-1:0] sh_m;
   logic [MND_W-1:0] sh_ninv;
   logic [MND_W-1:0] sh_dinv;
   logic [CFG_W-1:0] live_vec;
   logic [CFG_W-1:0] held_vec;
   logic             chg;
   logic             tick;
   logic             hit;
   logic             restart;
   logic             mnd_active;
   logic [HID_W-1:0] pre_cnt;
   logic [MND_W-1:0] acc;
   logic             pulse_q;

   assign live_vec = {cfg_prediv, cfg_mode, cfg_m, cfg_n_inv, cfg_d_inv};
   assign held_vec = {sh_pre, sh_mode, sh_m, sh_ninv, sh_dinv};
   assign chg      = (live_vec != held_vec);
   assign restart  = hit && chg;

   fcd_prestage #(.HID_W(HID_W), .HALF_STEP(HALF_STEP)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .cur_k   (sh_pre),
      .next_k  (cfg_prediv),
      .load    (hit),
      .restart (restart),
      .tick    (tick),
      .cnt_o   (pre_cnt)
   );

   fcd_mnd_stage #(.MND_W(MND_W), .ENABLE(USE_MND)) u_mnd (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .restart (restart),
      .mode    (sh_mode),
      .m       (sh_m),
      .n_inv   (sh_ninv),
      .d_inv   (sh_dinv),
      .hit     (hit),
      .active  (mnd_active),
      .acc_o   (acc)
   );

   // held configuration changes only on an output pulse
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_pre  <= '0;
         sh_mode <= '0;
         sh_m    <= '0;
         sh_ninv <= '0;
         sh_dinv <= '0;
         pulse_q <= 1'b0;
      end else begin
         pulse_q <= hit;
         if (hit) begin
            sh_pre  <= cfg_prediv;
            sh_mode <= cfg_mode;
            sh_m    <= cfg_m;
            sh_ninv <= cfg_n_inv;
            sh_dinv <= cfg_d_inv;
         end
      end
   end

   assign div_pulse = pulse_q;
endmodule

// File: rtl/frac_clk_div_checker.sv
module frac_clk_div_checker #(
   parameter int HID_W = 5,
   parameter int MND_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             div_pulse,
   input logic             tick,
   input logic             hit,
   input logic             mnd_active,
   input logic [HID_W-1:0] pre_cnt,
   input logic [HID_W-1:0] sh_pre,
   input logic [MND_W-1:0] sh_m,
   input logic [1:0]       sh_mode
);
   p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |=> ($stable(sh_pre) && $stable(sh_m) && $stable(sh_mode)));

   p_pulse_from_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      div_pulse |-> $past(tick));

   p_bypass_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !mnd_active) |=> div_pulse);

   p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= (sh_pre >> 1));
endmodule

bind frac_clk_div frac_clk_div_checker #(.HID_W(HID_W), .MND_W(MND_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .div_pulse  (div_pulse),
   .tick       (tick),
   .hit        (hit),
   .mnd_active (mnd_active),
   .pre_cnt    (pre_cnt),
   .sh_pre     (sh_pre),
   .sh_m       (sh_m),
   .sh_mode    (sh_mode)
);

// File: tb/frac_clk_div_bench.sv
module frac_clk_div_bench;
   localparam int HID_W = 5;
   localparam int MND_W = 8;
   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES = 150000;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [HID_W-1:0] cfg_prediv = '0;
   logic [1:0]       cfg_mode = '0;
   logic [MND_W-1:0] cfg_m = '0;
   logic [MND_W-1:0] cfg_n_inv = '0;
   logic [MND_W-1:0] cfg_d_inv = '0;
   logic             div_pulse;

   int total = 0;
   int bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   frac_clk_div #(.HID_W(HID_W), .MND_W(MND_W)) u_frac_clk_div (
      .clk(clk), .rst_n(rst_n), .cfg_prediv(cfg_prediv), .cfg_mode(cfg_mode),
      .cfg_m(cfg_m), .cfg_n_inv(cfg_n_inv), .cfg_d_inv(cfg_d_inv),
      .div_pulse(div_pulse)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(input int k, input int mode, input int m, input int n);
      cfg_prediv = HID_W'(k);
      cfg_mode   = 2'(mode);
      cfg_m      = MND_W'(m);
      cfg_n_inv  = ~MND_W'(n - m);
      cfg_d_inv  = ~MND_W'(n);
   endtask

   task automatic next_gap(output int g);
      g = 0;
      do begin
         @(negedge clk);
         g++;
      end while (!div_pulse && g < 400);
   endtask

   task automatic settle();
      int g;
      for (int i = 0; i < 3; i++) next_gap(g);
   endtask

   task automatic count_win(input int len, output int c);
      c = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         if (div_pulse) c++;
      end
   endtask

   task automatic t_reset();
      set_cfg(0, 0, 0, 0);
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(div_pulse == 1'b0, "R1 pulse low in reset", int'(div_pulse), 0);
      end
      rst_n = 1'b1;
      @(negedge clk);
      chk(div_pulse == 1'b1, "R1 first pulse after release", int'(div_pulse), 1);
   endtask

   task automatic t_div1();
      int g;
      for (int k = 0; k < 2; k++) begin
         set_cfg(k, 0, 0, 0);
         settle();
         for (int i = 0; i < 4; i++) begin
            next_gap(g);
            chk(g == 1, "R2 divide by one gap", g, 1);
         end
      end
   endtask

   task automatic t_odd(input int k);
      int g;
      set_cfg(k, 0, 0, 0);
      settle();
      for (int i = 0; i < 3; i++) begin
         next_gap(g);
         chk(g == (k + 1) / 2, "R3 odd field gap", g, (k + 1) / 2);
      end
   endtask

   task automatic t_half(input int k);
      int g [4];
      set_cfg(k, 0, 0, 0);
      settle();
      for (int i = 0; i < 4; i++) next_gap(g[i]);
      for (int i = 0; i < 4; i++)
         chk(g[i] == k / 2 || g[i] == k / 2 + 1, "R4 half step gap", g[i], k / 2);
      for (int i = 0; i < 3; i++)
         chk(g[i] != g[i+1], "R4 gaps alternate", g[i+1], (g[i] == k / 2) ? k / 2 + 1 : k / 2);
   endtask

   task automatic t_sat();
      int g;
      int kmax = (1 << HID_W) - 1;
      set_cfg(kmax, 0, 0, 0);
      settle();
      next_gap(g);
      chk(g == (1 << (HID_W - 1)), "R5 max field spacing", g, 1 << (HID_W - 1));
   endtask

   task automatic t_mnd_rate(input int k, input int m, input int n);
      int c;
      int r2 = ((k < 1) ? 1 : k) + 1;
      set_cfg(k, 2, m, n);
      settle();
      count_win(n * r2 * 4, c);
      chk(c == 2 * m * 4, "R6 fractional pulse count", c, 2 * m * 4);
   endtask

   task automatic t_mnd_gaps(input int m, input int n);
      int g;
      set_cfg(0, 2, m, n);
      settle();
      for (int i = 0; i < 6; i++) begin
         next_gap(g);
         chk(g == n / m || g == (n + m - 1) / m, "R8 fractional gap bounds", g, n / m);
      end
   endtask

   task automatic t_bypass(input int mode, input int m, input int n, input string tag);
      int g;
      set_cfg(3, mode, m, n);
      settle();
      next_gap(g);
      chk(g == 2, tag, g, 2);
   endtask

   task automatic t_boundary();
      int g;
      set_cfg(15, 0, 0, 0);
      settle();
      set_cfg(0, 0, 0, 0);
      for (int i = 0; i < 7; i++) begin
         @(negedge clk);
         chk(div_pulse == 1'b0, "R9 old interval kept", int'(div_pulse), 0);
      end
      @(negedge clk);
      chk(div_pulse == 1'b1, "R9 pulse ends old interval", int'(div_pulse), 1);
      @(negedge clk);
      chk(div_pulse == 1'b1, "R9 new setting adopted", int'(div_pulse), 1);
      set_cfg(0, 2, 1, 3);
      @(negedge clk);
      chk(div_pulse == 1'b1, "R9 load pulse", int'(div_pulse), 1);
      next_gap(g);
      chk(g == 3, "R9 accumulator cleared on change", g, 3);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", WD_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      t_reset();
      t_div1();
      t_odd(3);
      t_odd(5);
      t_half(2);
      t_half(4);
      t_sat();
      t_mnd_rate(0, 2, 5);
      t_mnd_rate(3, 3, 7);
      t_mnd_rate(4, 1, 3);
      t_mnd_gaps(2, 5);
      t_mnd_gaps(3, 7);
      t_bypass(1, 2, 5, "R7 mode not dual");
      t_bypass(2, 2, 0, "R7 n zero");
      t_bypass(2, 0, 5, "R7 m zero");
      t_bypass(2, 5, 5, "R7 m equals n");
      t_bypass(2, 6, 5, "R7 m above n");
      t_boundary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule